// File: doc/BRIEF.md
# Blanking Level and Range Scaler

This block sits in front of a triple video DAC. Each clock it takes one aligned three-component sample of 10 bits per component. The sample is either green/blue/red or luma/blue-difference/red-difference. The block produces the three codes the converter is driven with. A two-bit format mode selects the colour space and packing, and a range select chooses between full-scale and reduced studio range. A video/generic flag decides whether the range select is honoured at all.

While the active-low blank input is low, the block replaces the data with fixed levels. Those levels depend on the colour space and on the range in use. In reduced range, the first component passes through untouched and the other two are compressed digitally, so all three end up with the same output span. Codes outside the nominal studio range are not clipped, so overshoot and undershoot survive to the analog side.

The result always leaves two clocks after its input. The blank flag travels through the same two stages, so forced levels line up with the samples they replace.

Top module: `blank_range_scaler`

## Requirements
- R1: Outputs are registered with a latency of exactly two clocks from input to output. While rstN is low, all three outputs are 0.
- R2: fmtMode encoding: 0 is GBR 4:4:4, 1 is YCbCr 4:4:4, 2 is YCbCr 4:2:2 on two buses, 3 is YCbCr 4:2:2 on one bus. With videoMode high, modes 0 and 1 select reduced range when rangeSel is 1. Modes 2 and 3 select reduced range when rangeSel is 0.
- R3: With videoMode low, full range is used whatever rangeSel is, both for data and for blank levels.
- R4: When blankN is low in GBR mode, the outputs are 0/0/0 in full range and 64/64/64 in reduced range.
- R5: When blankN is low in any YCbCr mode, the outputs (outA/outB/outC) are 0/512/512 in full range and 64/512/512 in reduced range.
- R6: With blankN high, outA equals inA in every mode and range.
- R7: In full range with blankN high, outB and outC equal inB and inC, including codes 0 and 1023.
- R8: In reduced YCbCr range with blankN high, each of outB and outC equals 512 + ((x − 512)·4005 + 2048) >>> 12. The shift is arithmetic, 4005 is round(876/896·4096), and the result is saturated to 0..1023.
- R9: In reduced GBR range with blankN high, outB and outC use the same formula with 64 in place of 512.
- R10: Out-of-range inputs (super-black below 64, super-white above 940) are not clipped. Luma keeps its value, and chroma extremes 0 and 1023 map through the formula rather than to a limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtMode | input | 2 | Colour space / packing mode |
| rangeSel | input | 1 | Range select, polarity depends on fmtMode |
| videoMode | input | 1 | 1 = video mode, 0 = generic mode |
| blankN | input | 1 | Active-low blank |
| inA | input | 10 | G or Y component |
| inB | input | 10 | B or Cb component |
| inC | input | 10 | R or Cr component |
| outA | output | 10 | Code for the first DAC channel |
| outB | output | 10 | Code for the second DAC channel |
| outC | output | 10 | Code for the third DAC channel |

## Verification
The stimulus table sweeps every format mode with both range-select values and both video/generic settings. This exposes the inverted range polarity of the 4:2:2 modes and any failure to ignore the range select in generic mode. Mid-scale, foot and extreme chroma codes separate the two pivots (512 for YCbCr, 64 for GBR) and show whether rounding and saturation behave as specified. Super-black and super-white luma show whether any clipping is present. A streaming run with a single blanked cycle, and a step on one input, show that the blank flag and the data share the same two-cycle latency.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [1:0] {
    FMT_GBR444      = 2'd0,
    FMT_YCC444      = 2'd1,
    FMT_YCC422_DUAL = 2'd2,
    FMT_YCC422_ONE  = 2'd3
  } brs_fmt_e;

  typedef struct packed {
    logic scaleEn;   // reduced range active
    logic yccSpace;  // colour-difference space
    logic blankAct;  // force fixed levels
  } brs_strobe_t;
endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  fmtMode,
  input  logic        rangeSel,
  input  logic        videoMode,
  input  logic        blankN,
  output brs_strobe_t stb
);
  brs_fmt_e    fmt;
  logic        reducedReq;
  brs_strobe_t stbNext;

  always_comb begin
    fmt = brs_fmt_e'(fmtMode);
    unique case (fmt)
      FMT_GBR444, FMT_YCC444:          reducedReq = rangeSel;
      FMT_YCC422_DUAL, FMT_YCC422_ONE: reducedReq = ~rangeSel;
      default:                         reducedReq = 1'b0;
    endcase
    stbNext.scaleEn  = videoMode & reducedReq;
    stbNext.yccSpace = (fmt != FMT_GBR444);
    stbNext.blankAct = ~blankN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stb <= '0;
    else       stb <= stbNext;
  end
endmodule

// File: rtl/brs_chroma_scale.sv
module brs_chroma_scale #(
  parameter int DATA_W = 10,
  parameter int FRAC_W = 12,
  parameter int COEF   = 4005
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] pivot,
  output logic [DATA_W-1:0] scaled
);
  localparam int PW = DATA_W + FRAC_W + 6;
  localparam logic signed [PW-1:0] COEF_S = PW'(COEF);
  localparam logic signed [PW-1:0] HALF   = PW'(2 ** (FRAC_W - 1));
  localparam logic signed [PW-1:0] MAXV   = PW'(2 ** DATA_W - 1);

  logic signed [PW-1:0] diff, prod, rnd, sum;

  always_comb begin
    diff = $signed(PW'(sample)) - $signed(PW'(pivot));
    prod = diff * COEF_S;
    rnd  = (prod + HALF) >>> FRAC_W;
    sum  = rnd + $signed(PW'(pivot));
    if (sum < 0)         scaled = '0;
    else if (sum > MAXV) scaled = '1;
    else                 scaled = sum[DATA_W-1:0];
  end
endmodule

// File: rtl/brs_datapath.sv
module brs_datapath
  import brs_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int FRAC_W = 12,
  parameter int COEF   = 4005,
  parameter int FOOT   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  brs_strobe_t       stb,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic [DATA_W-1:0] inC,
  output logic [DATA_W-1:0] outA,
  output logic [DATA_W-1:0] outB,
  output logic [DATA_W-1:0] outC
);
  localparam logic [DATA_W-1:0] MID_CODE  = DATA_W'(2 ** (DATA_W - 1));
  localparam logic [DATA_W-1:0] FOOT_CODE = DATA_W'(FOOT);
  localparam int NCHROMA = 2;

  logic [DATA_W-1:0] regA;
  logic [DATA_W-1:0] regChroma [NCHROMA];
  logic [DATA_W-1:0] scaledChroma [NCHROMA];
  logic [DATA_W-1:0] nextChroma [NCHROMA];
  logic [DATA_W-1:0] pivot, blankA, blankChroma, nextA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA         <= '0;
      regChroma[0] <= '0;
      regChroma[1] <= '0;
    end else begin
      regA         <= inA;
      regChroma[0] <= inB;
      regChroma[1] <= inC;
    end
  end

  always_comb begin
    pivot       = stb.yccSpace ? MID_CODE : FOOT_CODE;
    blankA      = stb.scaleEn ? FOOT_CODE : '0;
    blankChroma = stb.yccSpace ? MID_CODE : blankA;
    nextA       = stb.blankAct ? blankA : regA;
  end

  for (genvar ch = 0; ch < NCHROMA; ch++) begin : g_chroma
    brs_chroma_scale #(
      .DATA_W(DATA_W), .FRAC_W(FRAC_W), .COEF(COEF)
    ) u_scale (
      .sample(regChroma[ch]),
      .pivot (pivot),
      .scaled(scaledChroma[ch])
    );
    always_comb begin
      if (stb.blankAct)     nextChroma[ch] = blankChroma;
      else if (stb.scaleEn) nextChroma[ch] = scaledChroma[ch];
      else                  nextChroma[ch] = regChroma[ch];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outA <= '0;
      outB <= '0;
      outC <= '0;
    end else begin
      outA <= nextA;
      outB <= nextChroma[0];
      outC <= nextChroma[1];
    end
  end
endmodule

// File: rtl/blank_range_scaler.sv
module blank_range_scaler
  import brs_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int FRAC_W      = 12,
  parameter int LUMA_SPAN   = 876,
  parameter int CHROMA_SPAN = 896,
  parameter int FOOT        = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        fmtMode,
  input  logic              rangeSel,
  input  logic              videoMode,
  input  logic              blankN,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic [DATA_W-1:0] inC,
  output logic [DATA_W-1:0] outA,
  output logic [DATA_W-1:0] outB,
  output logic [DATA_W-1:0] outC
);
  localparam int COEF = ((LUMA_SPAN * (2 ** FRAC_W)) + CHROMA_SPAN / 2) / CHROMA_SPAN;

  brs_strobe_t stb;

  brs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fmtMode(fmtMode), .rangeSel(rangeSel),
    .videoMode(videoMode), .blankN(blankN), .stb(stb)
  );

  brs_datapath #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .COEF(COEF), .FOOT(FOOT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inA(inA), .inB(inB), .inC(inC),
    .outA(outA), .outB(outB), .outC(outC)
  );
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        fmtMode,
  input logic              rangeSel,
  input logic              videoMode,
  input logic              blankN,
  input logic [DATA_W-1:0] inA,
  input logic [DATA_W-1:0] inB,
  input logic [DATA_W-1:0] inC,
  input logic [DATA_W-1:0] outA,
  input logic [DATA_W-1:0] outB,
  input logic [DATA_W-1:0] outC
);
  localparam logic [DATA_W-1:0] MID  = DATA_W'(2 ** (DATA_W - 1));
  localparam logic [DATA_W-1:0] FOOT = DATA_W'(64);

  logic [1:0] age;
  logic       redNow, yccNow, seen;

  always_comb begin
    redNow = videoMode & (fmtMode[1] ? ~rangeSel : rangeSel);
    yccNow = (fmtMode != 2'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign seen = (age >= 2'd2);

  // R1: reset holds outputs at zero
  always @(posedge clk)
    if (rstN === 1'b0)
      a_r1_reset_zero: assert (outA == '0 && outB == '0 && outC == '0);

  a_r6_luma_pass: assert property (@(posedge clk) disable iff (!rstN)
    seen && $past(blankN, 2) |-> outA == $past(inA, 2));

  a_r4_blank_first: assert property (@(posedge clk) disable iff (!rstN)
    seen && !$past(blankN, 2) |-> outA == ($past(redNow, 2) ? FOOT : '0));

  a_r5_blank_ycc: assert property (@(posedge clk) disable iff (!rstN)
    seen && !$past(blankN, 2) && $past(yccNow, 2) |-> outB == MID && outC == MID);

  a_r4_blank_gbr: assert property (@(posedge clk) disable iff (!rstN)
    seen && !$past(blankN, 2) && !$past(yccNow, 2) |-> outB == outA && outC == outA);

  a_r7_full_pass: assert property (@(posedge clk) disable iff (!rstN)
    seen && $past(blankN, 2) && !$past(redNow, 2)
      |-> outB == $past(inB, 2) && outC == $past(inC, 2));

  a_r3_generic_full: assert property (@(posedge clk) disable iff (!rstN)
    seen && $past(blankN, 2) && !$past(videoMode, 2) |-> outB == $past(inB, 2));

  a_r8_mid_fixed: assert property (@(posedge clk) disable iff (!rstN)
    seen && $past(blankN, 2) && $past(redNow, 2) && $past(yccNow, 2) && $past(inB, 2) == MID
      |-> outB == MID);
endmodule

bind blank_range_scaler brs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .fmtMode(fmtMode), .rangeSel(rangeSel),
  .videoMode(videoMode), .blankN(blankN), .inA(inA), .inB(inB), .inC(inC),
  .outA(outA), .outB(outB), .outC(outC)
);

// File: tb/sim_blank_range_scaler.sv
`timescale 1ns/1ps
module sim_blank_range_scaler;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] fmtMode = '0;
  logic rangeSel = 1'b0, videoMode = 1'b1, blankN = 1'b1;
  logic [9:0] inA = '0, inB = '0, inC = '0;
  logic [9:0] outA, outB, outC;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  blank_range_scaler u0 (
    .clk(clk), .rstN(rstN), .fmtMode(fmtMode), .rangeSel(rangeSel),
    .videoMode(videoMode), .blankN(blankN), .inA(inA), .inB(inB), .inC(inC),
    .outA(outA), .outB(outB), .outC(outC)
  );

  // {fmt, rangeSel, videoMode, blankN, A, B, C}
  localparam int NV = 18;
  localparam logic [34:0] VECS [NV] = '{
    {2'd0,1'b0,1'b1,1'b1,10'd100,10'd200,10'd300},   // R7 R6 GBR full
    {2'd0,1'b1,1'b1,1'b1,10'd500,10'd64,10'd940},    // R9 GBR reduced
    {2'd0,1'b1,1'b1,1'b1,10'd4,10'd0,10'd1023},      // R9 R10 extremes
    {2'd1,1'b1,1'b1,1'b1,10'd1020,10'd512,10'd960},  // R8 R10 super-white
    {2'd1,1'b1,1'b1,1'b1,10'd0,10'd0,10'd1023},      // R8 R10 chroma limits
    {2'd1,1'b0,1'b1,1'b1,10'd37,10'd0,10'd1023},     // R7 YCC full
    {2'd2,1'b0,1'b1,1'b1,10'd300,10'd100,10'd800},   // R2 422 rng0 reduced
    {2'd2,1'b1,1'b1,1'b1,10'd300,10'd100,10'd800},   // R2 422 rng1 full
    {2'd3,1'b0,1'b1,1'b1,10'd9,10'd700,10'd333},     // R2 single-bus reduced
    {2'd3,1'b1,1'b1,1'b1,10'd9,10'd700,10'd333},     // R2 single-bus full
    {2'd0,1'b1,1'b0,1'b1,10'd1,10'd2,10'd1000},      // R3 generic GBR
    {2'd2,1'b0,1'b0,1'b1,10'd1,10'd20,10'd1010},     // R3 generic 422
    {2'd0,1'b0,1'b1,1'b0,10'd400,10'd400,10'd400},   // R4 blank GBR full
    {2'd0,1'b1,1'b1,1'b0,10'd400,10'd400,10'd400},   // R4 blank GBR reduced
    {2'd1,1'b0,1'b1,1'b0,10'd400,10'd400,10'd400},   // R5 blank YCC full
    {2'd3,1'b0,1'b1,1'b0,10'd400,10'd400,10'd400},   // R5 blank YCC reduced
    {2'd0,1'b1,1'b0,1'b0,10'd400,10'd400,10'd400},   // R3 R4 generic blank GBR
    {2'd2,1'b0,1'b0,1'b0,10'd400,10'd400,10'd400}    // R3 R5 generic blank YCC
  };

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int scaleRef(input int x, input int piv);
    int t;
    t = ((x - piv) * 4005 + 2048) >>> 12;
    t = t + piv;
    if (t < 0) t = 0;
    if (t > 1023) t = 1023;
    return t;
  endfunction

  task automatic model(input logic [34:0] v, output int ea, output int eb, output int ec);
    logic [1:0] f;
    logic rs, vm, bn, red, ycc;
    int piv;
    {f, rs, vm, bn} = v[34:30];
    red = vm && (f[1] ? !rs : rs);   // R2 R3
    ycc = (f != 2'd0);
    if (!bn) begin
      ea = red ? 64 : 0;
      eb = ycc ? 512 : ea;
      ec = eb;
    end else begin
      ea = int'(v[29:20]);
      piv = ycc ? 512 : 64;
      eb = red ? scaleRef(int'(v[19:10]), piv) : int'(v[19:10]);
      ec = red ? scaleRef(int'(v[9:0]), piv) : int'(v[9:0]);
    end
  endtask

  initial begin
    int ea, eb, ec;
    repeat (3) @(negedge clk);
    chk("R1 reset outA", int'(outA), 0);
    chk("R1 reset outB", int'(outB), 0);
    chk("R1 reset outC", int'(outC), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {fmtMode, rangeSel, videoMode, blankN, inA, inB, inC} = VECS[i];
      @(posedge clk); @(posedge clk); @(negedge clk);
      model(VECS[i], ea, eb, ec);
      chk($sformatf("R2-R10 vec%0d outA", i), int'(outA), ea);
      chk($sformatf("R2-R10 vec%0d outB", i), int'(outB), eb);
      chk($sformatf("R2-R10 vec%0d outC", i), int'(outC), ec);
    end

    // R1 latency step on luma
    fmtMode = 2'd0; rangeSel = 1'b0; videoMode = 1'b1; blankN = 1'b1; inA = 10'd111;
    @(posedge clk); @(posedge clk); @(negedge clk);
    inA = 10'd777;
    @(posedge clk); @(negedge clk);
    chk("R1 one cycle old", int'(outA), 111);
    @(posedge clk); @(negedge clk);
    chk("R1 two cycle new", int'(outA), 777);

    // R1 R4 streaming with one blanked cycle
    for (int i = 0; i < 10; i++) begin
      inA = 10'(10 * i + 5);
      blankN = (i != 4);
      @(posedge clk); @(negedge clk);
      if (i >= 1)
        chk("R1 R4 stream outA", int'(outA), (i - 1 == 4) ? 0 : 10 * (i - 1) + 5);
    end

    // R1 reset mid-run
    blankN = 1'b1; inA = 10'd555; inB = 10'd444; inC = 10'd333;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1 mid reset outA", int'(outA), 0);
    chk("R1 mid reset outC", int'(outC), 0);
    @(negedge clk);
    rstN = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule